// File: doc/BRIEF.md
# Synchronized DMA Request Routing Channel

This block is a single channel of a DMA request multiplexer. It picks one request line out of a wide input vector using a 7-bit identifier and drives the chosen line toward one DMA channel. In free-running mode the chosen line passes straight through. In gated mode the channel waits for a qualified edge on one of several synchronization inputs. It then forwards a fixed number of requests and disconnects again.

An internal down-counter tracks requests that the DMA side reports as served. Each time the counter runs out it reloads from the programmed count and can emit a one-clock event pulse. A synchronization edge that lands while a burst is still running sets a sticky overrun flag. That flag can raise an interrupt. The channel is set up through one 32-bit configuration word written in a single cycle.

Top module: `dma_route_chan`

## Requirements
- R1: Configuration field positions are: request identifier in bits [6:0], overrun interrupt enable in bit 8, event enable in bit 9, gate enable in bit 16, edge select in bits [18:17], burst count in bits [23:19], and sync input select in bits [26:24]. An identifier k in 1..NUM_REQ routes `req_in[k-1]`. Identifier 0 routes nothing. With the gate disabled, `req_out` follows the selected line in the same cycle.
- R2: The edge select encodings are 00 = no detection, 01 = rising, 10 = falling and 11 = either. Only the sync input named by bits [26:24] is watched.
- R3: With the gate enabled, a qualified edge that arrives while the selected line is high connects the line to `req_out`. The line stays connected for burst count + 1 served requests and is then disconnected.
- R4: A qualified edge that arrives while the selected line is low is dropped. A request that rises afterwards stays blocked until a further edge arrives.
- R5: A sync edge qualifies only after the new level has been seen on at least three consecutive synchronized samples. Shorter pulses are ignored.
- R6: Sync edges that would qualify during the three clocks after a configuration write are consumed without effect.
- R7: A served request counts only while `req_out` is high. When the counter underruns it reloads the burst count. If the event enable is set, `evt_out` then pulses for exactly one clock. With burst count 0, every served request gives an event.
- R8: A qualified edge that arrives while a burst is connected sets `ovr_flag`. The flag holds until `ovr_clr` is pulsed. `ovr_irq` equals the flag ANDed with the overrun interrupt enable.
- R9: A configuration write updates the burst count only if the gate enable and the event enable were both 0 before the write. Otherwise the old count is kept. Every write drops the connection and reloads the counter.
- R10: After reset all outputs are 0 and the channel is unconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | NUM_REQ | Candidate request lines |
| sync_in | input | NUM_SYNC | Asynchronous synchronization inputs |
| served | input | 1 | One-clock pulse: the routed request was served |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| ovr_clr | input | 1 | Clears the overrun flag |
| req_out | output | 1 | Routed request |
| evt_out | output | 1 | One-clock event on counter reload |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The bench walks the identifier boundaries 0, 1, 64 and the top value. A decoder that is off by one, or that treats identifier 0 as a line, shows up there. The bench times bursts of served requests. A counter that reloads early or late gives the wrong number of forwarded requests or misplaced event pulses. It sends sync pulses of two and three clocks, and times an edge to land inside the post-write mask window. A filter or mask of the wrong length then shows up as a request that wrongly connects or never does. It also writes a new burst count while the channel is active and checks that the old event spacing is kept. It sends an edge with no pending request and checks that the later request stays blocked. Finally, it forces an overrun and checks the flag, the interrupt and the clear.

// File: rtl/dma_route_chan.sv
module dma_route_chan #(
  parameter int NUM_REQ  = 127,
  parameter int NUM_SYNC = 8,
  parameter int MASK_CYC = 3,
  parameter int FILT_LEN = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REQ-1:0]  req_in,
  input  logic [NUM_SYNC-1:0] sync_in,
  input  logic                served,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_wdata,
  input  logic                ovr_clr,
  output logic                req_out,
  output logic                evt_out,
  output logic                ovr_flag,
  output logic                ovr_irq
);
  localparam int MW = $clog2(MASK_CYC + 1);

  logic [6:0] id_q;
  logic [4:0] nb_q, cnt_q, nb_new;
  logic [2:0] ssel_q;
  logic [1:0] pol_q;
  logic       oie_q, ege_q, se_q, conn;
  logic [MW-1:0] mask_q;

  logic [NUM_SYNC-1:0] s1, s2;
  logic [FILT_LEN-1:0] hist;
  logic acc, sel_sync, sel_req, settled, changed, pol_hit, sync_evt, served_ok;

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31:27], cfg_wdata[15:10], cfg_wdata[7]};

  always_comb begin
    sel_req = 1'b0;
    if (id_q != 7'd0 && int'(id_q) <= NUM_REQ) sel_req = req_in[id_q - 7'd1];
  end

  always_comb begin
    sel_sync = 1'b0;
    if (int'(ssel_q) < NUM_SYNC) sel_sync = s2[ssel_q];
  end

  assign settled   = (&hist) | ~(|hist);
  assign changed   = settled && (hist[0] != acc);
  assign pol_hit   = changed && ((hist[0] && pol_q[0]) || (!hist[0] && pol_q[1]));
  assign sync_evt  = se_q && pol_hit && (mask_q == '0);
  assign req_out   = sel_req && (!se_q || conn);
  assign served_ok = served && req_out;
  assign nb_new    = (!se_q && !ege_q) ? cfg_wdata[23:19] : nb_q;
  assign ovr_irq   = ovr_flag && oie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      hist <= '0;
      acc  <= 1'b0;
    end else begin
      s1   <= sync_in;
      s2   <= s1;
      hist <= {hist[FILT_LEN-2:0], sel_sync};
      if (changed) acc <= hist[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= '0;
      oie_q   <= 1'b0;
      ege_q   <= 1'b0;
      se_q    <= 1'b0;
      pol_q   <= '0;
      nb_q    <= '0;
      ssel_q  <= '0;
      cnt_q   <= '0;
      conn    <= 1'b0;
      mask_q  <= '0;
      evt_out <= 1'b0;
    end else begin
      evt_out <= 1'b0;
      if (cfg_we) begin
        id_q   <= cfg_wdata[6:0];
        oie_q  <= cfg_wdata[8];
        ege_q  <= cfg_wdata[9];
        se_q   <= cfg_wdata[16];
        pol_q  <= cfg_wdata[18:17];
        ssel_q <= cfg_wdata[26:24];
        nb_q   <= nb_new;
        cnt_q  <= nb_new;
        conn   <= 1'b0;
        mask_q <= MW'(MASK_CYC);
      end else begin
        if (mask_q != '0) mask_q <= mask_q - MW'(1);
        if (served_ok) begin
          if (cnt_q == '0) begin
            cnt_q   <= nb_q;
            evt_out <= ege_q;
            if (se_q) conn <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 5'd1;
          end
        end
        if (sync_evt && !conn && sel_req) conn <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_flag <= 1'b0;
    else if (sync_evt && conn) ovr_flag <= 1'b1;
    else if (ovr_clr) ovr_flag <= 1'b0;
  end
endmodule

// File: rtl/dma_route_chan_chk.sv
module dma_route_chan_chk #(
  parameter int NUM_REQ = 127
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [NUM_REQ-1:0] req_in,
  input logic               req_out,
  input logic               served,
  input logic               evt_out,
  input logic               ovr_flag,
  input logic               ovr_clr,
  input logic               ovr_irq,
  input logic               conn
);
  // R1
  req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> (|req_in));

  // R7
  evt_after_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_out |-> $past(served));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq |-> ovr_flag);

  // R9
  write_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !conn);
endmodule

bind dma_route_chan dma_route_chan_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .req_in(req_in),
  .req_out(req_out), .served(served), .evt_out(evt_out),
  .ovr_flag(ovr_flag), .ovr_clr(ovr_clr), .ovr_irq(ovr_irq), .conn(conn)
);

// File: tb/test_dma_route_chan.sv
module test_dma_route_chan;
  localparam int NR = 127;
  localparam int NS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0] req_in = '0;
  logic [NS-1:0] sync_in = '0;
  logic served = 1'b0, cfg_we = 1'b0, ovr_clr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic req_out, evt_out, ovr_flag, ovr_irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  dma_route_chan #(.NUM_REQ(NR), .NUM_SYNC(NS)) i_dma_route_chan (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .sync_in(sync_in),
    .served(served), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ovr_clr(ovr_clr),
    .req_out(req_out), .evt_out(evt_out), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq));

  // {all_ones, id[6:0], bitpos[6:0], expected}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 7'd1,   7'd0,   1'b1},
    {1'b0, 7'd1,   7'd1,   1'b0},
    {1'b0, 7'd2,   7'd1,   1'b1},
    {1'b0, 7'd127, 7'd126, 1'b1},
    {1'b0, 7'd127, 7'd125, 1'b0},
    {1'b0, 7'd64,  7'd63,  1'b1},
    {1'b1, 7'd0,   7'd0,   1'b0},
    {1'b1, 7'd100, 7'd0,   1'b1}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic wcfg(input logic [6:0] id, input logic oie, input logic ege,
                      input logic se, input logic [1:0] pol, input logic [4:0] nb,
                      input logic [2:0] ssel);
    cfg_wdata = {5'b0, ssel, nb, pol, se, 6'b0, ege, oie, 1'b0, id};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic serve();
    served = 1'b1;
    @(negedge clk);
    served = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    chk("R10 req_out", req_out, 1'b0);
    chk("R10 evt_out", evt_out, 1'b0);
    chk("R10 ovr_flag", ovr_flag, 1'b0);
    chk("R10 ovr_irq", ovr_irq, 1'b0);
    rst_n = 1'b1;
    wait_n(2);
    req_in = '1;
    @(negedge clk);
    chk("R10 unconfigured", req_out, 1'b0);

    for (int i = 0; i < 8; i++) begin
      wcfg(VEC[i][14:8], 1'b0, 1'b0, 1'b0, 2'b00, 5'd0, 3'd0);
      req_in = VEC[i][15] ? '1 : (NR'(1) << VEC[i][7:1]);
      @(negedge clk);
      chk("R1 passthrough", req_out, VEC[i][0]);
    end

    // R7: event every third serve with burst count 2
    req_in = NR'(1) << 4;
    wcfg(7'd5, 1'b0, 1'b1, 1'b0, 2'b00, 5'd2, 3'd0);
    serve(); chk("R7 no evt 1", evt_out, 1'b0);
    serve(); chk("R7 no evt 2", evt_out, 1'b0);
    serve(); chk("R7 evt 3", evt_out, 1'b1);
    @(negedge clk); chk("R7 one clock", evt_out, 1'b0);

    // R9: count write ignored while event enable set
    wcfg(7'd5, 1'b0, 1'b1, 1'b0, 2'b00, 5'd0, 3'd0);
    serve(); chk("R9 kept count", evt_out, 1'b0);
    wcfg(7'd5, 1'b0, 1'b0, 1'b0, 2'b00, 5'd0, 3'd0);
    wcfg(7'd5, 1'b0, 1'b1, 1'b0, 2'b00, 5'd0, 3'd0);
    serve(); chk("R7 nb0 evt a", evt_out, 1'b1);
    serve(); chk("R7 nb0 evt b", evt_out, 1'b1);

    // R3: gated burst of two
    wcfg(7'd5, 1'b0, 1'b0, 1'b0, 2'b00, 5'd1, 3'd0);
    wcfg(7'd5, 1'b0, 1'b0, 1'b1, 2'b01, 5'd1, 3'd2);
    @(negedge clk);
    chk("R3 blocked before edge", req_out, 1'b0);
    sync_in[2] = 1'b1; wait_n(8);
    chk("R3 connected", req_out, 1'b1);
    serve(); chk("R3 after 1 serve", req_out, 1'b1);
    serve(); chk("R3 after 2 serves", req_out, 1'b0);
    sync_in[2] = 1'b0; wait_n(8);
    chk("R2 fall ignored on rise mode", req_out, 1'b0);

    // R4: edge with no pending request
    req_in = '0;
    sync_in[2] = 1'b1; wait_n(8);
    req_in = NR'(1) << 4; wait_n(4);
    chk("R4 dropped edge", req_out, 1'b0);
    sync_in[2] = 1'b0; wait_n(8);
    sync_in[2] = 1'b1; wait_n(8);
    chk("R4 next edge connects", req_out, 1'b1);

    // R8: overrun
    sync_in[2] = 1'b0; wait_n(8);
    sync_in[2] = 1'b1; wait_n(8);
    chk("R8 flag set", ovr_flag, 1'b1);
    chk("R8 irq off", ovr_irq, 1'b0);
    wcfg(7'd5, 1'b1, 1'b0, 1'b1, 2'b01, 5'd1, 3'd2);
    chk("R8 flag survives write", ovr_flag, 1'b1);
    chk("R8 irq on", ovr_irq, 1'b1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk("R8 cleared", ovr_flag, 1'b0);
    chk("R8 irq cleared", ovr_irq, 1'b0);

    // R5: filter length
    sync_in[2] = 1'b0; wait_n(8);
    sync_in[2] = 1'b1; wait_n(2); sync_in[2] = 1'b0; wait_n(8);
    chk("R5 short pulse ignored", req_out, 1'b0);
    sync_in[2] = 1'b1; wait_n(3); sync_in[2] = 1'b0; wait_n(8);
    chk("R5 three clocks accepted", req_out, 1'b1);

    // R2: falling and none
    wcfg(7'd5, 1'b0, 1'b0, 1'b1, 2'b10, 5'd1, 3'd2);
    sync_in[2] = 1'b1; wait_n(8);
    chk("R2 rise ignored on fall mode", req_out, 1'b0);
    sync_in[2] = 1'b0; wait_n(8);
    chk("R2 fall connects", req_out, 1'b1);
    wcfg(7'd5, 1'b0, 1'b0, 1'b1, 2'b00, 5'd1, 3'd2);
    sync_in[2] = 1'b1; wait_n(8); sync_in[2] = 1'b0; wait_n(8);
    chk("R2 no detection", req_out, 1'b0);
    wcfg(7'd5, 1'b0, 1'b0, 1'b1, 2'b11, 5'd1, 3'd3);
    sync_in[2] = 1'b1; wait_n(8);
    chk("R2 other input ignored", req_out, 1'b0);
    sync_in[2] = 1'b0;

    // R6: edge lands inside the post-write mask
    wcfg(7'd5, 1'b0, 1'b0, 1'b1, 2'b11, 5'd1, 3'd2);
    wait_n(8);
    sync_in[2] = 1'b1;
    wait_n(4);
    wcfg(7'd5, 1'b0, 1'b0, 1'b1, 2'b11, 5'd1, 3'd2);
    wait_n(8);
    chk("R6 masked edge", req_out, 1'b0);
    sync_in[2] = 1'b0; wait_n(8);
    chk("R6 later edge connects", req_out, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule